// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous Static Memory

This block is a synchronous static memory with registered inputs and a registered output. Each rising clock edge samples the address, the chip select, the write command, the lane-write controls and the data input. A read accepted on one edge delivers its word from the output register after the following edge. A write follows a late-write protocol: its address and lane controls are sampled with the command, and its data is taken from the data input on the next edge.

Write data is held in a one-entry write buffer until the array can take it. The buffer is drained when the next write command is accepted, or on a deselected cycle, so the array is never read and written on behalf of two different commands in the same cycle. A read that targets the address held in the buffer gets the buffered lanes merged over the array contents.

The word is made of 9-bit lanes, and the lane count is a parameter (4 lanes for a 36-bit word, 2 for an 18-bit word). The memory depth is also a parameter. Because the data pins are shared between input and output, the output side is modelled as a data bus plus a separate drive-enable. That enable is gated by an output enable that acts asynchronously.

Top module: `lw_sram`

## Requirements
- R1: After reset `dout_en` is low. A read accepted on edge E (sel=1, pdn=0, wr_en=0) makes `dout_en` high only in the cycle after edge E+1, when `dout` carries the word.
- R2: For a write accepted on edge E, the word is taken from `din` on edge E+1, and later reads return it.
- R3: A read accepted on the edge right after a write command to the same address returns the new data, with the write's lanes merged over the older contents. The same holds for any read while that write is still uncommitted.
- R4: When `all_lanes` is 0, only the lanes l with `lane_en[l]`=1 are written. Lane l covers bits [9l+8:9l], and the other lanes keep their old contents.
- R5: When `all_lanes` is 1, every lane is written, whatever `lane_en` holds.
- R6: `oe` acts combinationally with no clock. While `oe` is 0, `dout_en` is 0 and `dout` is all zeros. While `oe` is 1, `dout_en` follows the output-valid state.
- R7: While `pdn` is 1 on an edge, no read or write is accepted and the array is not written. Data for a write accepted on the edge before still goes into the write buffer.
- R8: While `sel` is 0 on an edge, no command is accepted, whatever `wr_en` holds. A pending buffered write may commit in that cycle.
- R9: At most one uncommitted write is held, either waiting for data or in the buffer. The buffer never commits on an edge that accepts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| pdn | input | 1 | Synchronous power-down, sampled on the edge |
| sel | input | 1 | Synchronous chip select, active high |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| all_lanes | input | 1 | Global write: forces every lane to be written |
| lane_en | input | LANES | Per-lane write enables |
| addr | input | AW | Word address |
| din | input | LANES*9 | Write data, one edge after the write command |
| oe | input | 1 | Asynchronous output enable |
| dout | output | LANES*9 | Read data from the output register, zero while oe is 0 |
| dout_en | output | 1 | Output drive enable (valid read word and oe high) |

## Verification
Two functions can fall into the same cycle here. One is the late data of a write arriving into the buffer; the other is a read capture of that same address, which has to forward the buffered lanes. The bench provokes this with back-to-back write-then-read pairs using partial lane masks. It also uses long random mixes over eight addresses, so buffer fills, direct commits, deselect commits and forwarded reads all overlap. Each read is judged against a behavioural reference array. In that array every write lands on the edge after its command, and each read takes a snapshot on its own capture edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_IDLE  = 2'd3
  } op_e;
endpackage

// File: rtl/lw_cmd_ctrl.sv
module lw_cmd_ctrl
  import lw_sram_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 8,
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn,
  input  logic             sel,
  input  logic             wr_en,
  input  logic             all_lanes,
  input  logic [LANES-1:0] lane_en,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     din,
  output op_e              op,
  output logic             commit_v,
  output logic [AW-1:0]    commit_addr,
  output logic [LANES-1:0] commit_mask,
  output logic [W-1:0]     commit_data,
  output logic             pend_v,
  output logic             buf_v,
  output logic [AW-1:0]    buf_addr,
  output logic [LANES-1:0] buf_mask,
  output logic [W-1:0]     buf_data,
  output logic             rd_v,
  output logic [AW-1:0]    rd_addr
);

  function automatic logic [LANES-1:0] write_mask(input logic force_all,
                                                  input logic [LANES-1:0] per_lane);
    return force_all ? {LANES{1'b1}} : per_lane;
  endfunction

  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_mask;
  logic             drain_slot;

  always_comb begin
    if (pdn)        op = OP_NONE;
    else if (!sel)  op = OP_IDLE;
    else if (wr_en) op = OP_WRITE;
    else            op = OP_READ;
  end

  // array port is free on write or deselected cycles
  assign drain_slot = (op == OP_WRITE) || (op == OP_IDLE);
  assign commit_v   = drain_slot && (pend_v || buf_v);

  always_comb begin
    if (pend_v) begin
      commit_addr = pend_addr;
      commit_mask = pend_mask;
      commit_data = din;
    end else begin
      commit_addr = buf_addr;
      commit_mask = buf_mask;
      commit_data = buf_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
      buf_v     <= 1'b0;
      buf_addr  <= '0;
      buf_mask  <= '0;
      buf_data  <= '0;
      rd_v      <= 1'b0;
      rd_addr   <= '0;
    end else begin
      rd_v   <= (op == OP_READ);
      pend_v <= (op == OP_WRITE);
      if (op == OP_READ) rd_addr <= addr;
      if (op == OP_WRITE) begin
        pend_addr <= addr;
        pend_mask <= write_mask(all_lanes, lane_en);
      end
      if (pend_v && !commit_v) begin
        buf_v    <= 1'b1;
        buf_addr <= pend_addr;
        buf_mask <= pend_mask;
        buf_data <= din;
      end else if (commit_v) begin
        buf_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lw_lane_array.sv
module lw_lane_array
  import lw_sram_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             wr_v,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_mask,
  input  logic [W-1:0]     wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_v && wr_mask[l])
        cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/lw_read_out.sv
module lw_read_out
  import lw_sram_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 8,
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_v,
  input  logic [AW-1:0]    rd_addr,
  input  logic [W-1:0]     arr_data,
  input  logic             buf_v,
  input  logic [AW-1:0]    buf_addr,
  input  logic [LANES-1:0] buf_mask,
  input  logic [W-1:0]     buf_data,
  input  logic             oe,
  output logic             fwd_hit,
  output logic             out_vld,
  output logic [W-1:0]     dout,
  output logic             dout_en
);

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] base,
                                              input logic [W-1:0] upd,
                                              input logic [LANES-1:0] m);
    logic [W-1:0] r;
    r = base;
    for (int l = 0; l < LANES; l++)
      if (m[l]) r[l*LANE_W +: LANE_W] = upd[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [W-1:0] dout_q;
  logic [W-1:0] rd_word;

  assign fwd_hit = buf_v && (buf_addr == rd_addr);
  assign rd_word = fwd_hit ? lane_merge(arr_data, buf_data, buf_mask) : arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      dout_q  <= '0;
    end else begin
      out_vld <= rd_v;
      if (rd_v) dout_q <= rd_word;
    end
  end

  assign dout    = oe ? dout_q : '0;
  assign dout_en = oe && out_vld;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn,
  input  logic             sel,
  input  logic             wr_en,
  input  logic             all_lanes,
  input  logic [LANES-1:0] lane_en,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     din,
  input  logic             oe,
  output logic [W-1:0]     dout,
  output logic             dout_en
);

  op_e              op;
  logic             commit_v;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_mask;
  logic [W-1:0]     commit_data;
  logic             pend_v;
  logic             buf_v;
  logic [AW-1:0]    buf_addr;
  logic [LANES-1:0] buf_mask;
  logic [W-1:0]     buf_data;
  logic             rd_v;
  logic [AW-1:0]    rd_addr;
  logic [W-1:0]     arr_data;
  logic             fwd_hit;
  logic             out_vld;

  // named events for the checker
  logic             ev_rd_acc;
  logic             ev_wr_acc;
  assign ev_rd_acc = (op == OP_READ);
  assign ev_wr_acc = (op == OP_WRITE);

  lw_cmd_ctrl #(.LANES(LANES), .AW(AW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .sel(sel), .wr_en(wr_en),
    .all_lanes(all_lanes), .lane_en(lane_en), .addr(addr), .din(din),
    .op(op), .commit_v(commit_v), .commit_addr(commit_addr),
    .commit_mask(commit_mask), .commit_data(commit_data),
    .pend_v(pend_v), .buf_v(buf_v), .buf_addr(buf_addr),
    .buf_mask(buf_mask), .buf_data(buf_data),
    .rd_v(rd_v), .rd_addr(rd_addr)
  );

  lw_lane_array #(.LANES(LANES), .DEPTH(DEPTH)) i_array (
    .clk(clk), .wr_v(commit_v), .wr_addr(commit_addr),
    .wr_mask(commit_mask), .wr_data(commit_data),
    .rd_addr(rd_addr), .rd_data(arr_data)
  );

  lw_read_out #(.LANES(LANES), .AW(AW)) i_out (
    .clk(clk), .rst_n(rst_n), .rd_v(rd_v), .rd_addr(rd_addr),
    .arr_data(arr_data), .buf_v(buf_v), .buf_addr(buf_addr),
    .buf_mask(buf_mask), .buf_data(buf_data), .oe(oe),
    .fwd_hit(fwd_hit), .out_vld(out_vld), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pdn,
  input logic         sel,
  input logic         wr_en,
  input logic         oe,
  input logic [W-1:0] dout,
  input logic         dout_en,
  input logic         commit_v,
  input logic         pend_v,
  input logic         buf_v,
  input logic         out_vld
);

  // R9
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_v && buf_v));

  // R9
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_v |-> !(sel && !pdn && !wr_en));

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !pdn && !wr_en) |=> ##1 out_vld);

  // R6
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0 && !dout_en));

  // R7
  pdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn && !pend_v) |=> (!pend_v && buf_v == $past(buf_v)));

  // R2
  late_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !commit_v) |=> buf_v);
endmodule

bind lw_sram lw_sram_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pdn(pdn), .sel(sel), .wr_en(wr_en),
  .oe(oe), .dout(dout), .dout_en(dout_en), .commit_v(commit_v),
  .pend_v(pend_v), .buf_v(buf_v), .out_vld(out_vld)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;
  localparam int LN = 4;
  localparam int DW = LN * 9;
  localparam int AWB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pdn = 1'b0;
  logic          sel = 1'b0;
  logic          wr_en = 1'b0;
  logic          all_lanes = 1'b0;
  logic [LN-1:0] lane_en = '0;
  logic [AWB-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          oe = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #2 clk = ~clk;

  lw_sram #(.LANES(LN), .DEPTH(256)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .sel(sel), .wr_en(wr_en),
    .all_lanes(all_lanes), .lane_en(lane_en), .addr(addr), .din(din),
    .oe(oe), .dout(dout), .dout_en(dout_en)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] ref_mem [int];
  bit            m_pend_v = 0;
  int            m_pend_addr = 0;
  logic [LN-1:0] m_pend_mask = '0;
  bit            m_rd_v = 0;
  logic [DW-1:0] m_rd_val = '0;
  bit            exp_vld = 0;
  logic [DW-1:0] exp_dout = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag);
    chk(tag, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, (oe && exp_vld)});
    if (oe && exp_vld) chk(tag, dout, exp_dout);
    if (!oe) chk(tag, dout, '0);
  endtask

  task automatic step(input string tag, input bit s, input bit w, input bit g,
                      input logic [LN-1:0] ln, input int a, input logic [DW-1:0] d,
                      input bit p);
    logic [DW-1:0] nv;
    bit acc;
    @(negedge clk);
    look(tag);
    sel = s; wr_en = w; all_lanes = g; lane_en = ln;
    addr = a[AWB-1:0]; din = d; pdn = p;
    exp_vld = m_rd_v;
    if (m_rd_v) exp_dout = m_rd_val;
    if (m_pend_v) begin
      nv = ref_mem.exists(m_pend_addr) ? ref_mem[m_pend_addr] : '0;
      for (int l = 0; l < LN; l++)
        if (m_pend_mask[l]) nv[l*9 +: 9] = d[l*9 +: 9];
      ref_mem[m_pend_addr] = nv;
    end
    acc = s && !p;
    m_rd_v = acc && !w;
    if (m_rd_v) m_rd_val = ref_mem.exists(a) ? ref_mem[a] : '0;
    m_pend_v = acc && w;
    m_pend_addr = a;
    m_pend_mask = g ? {LN{1'b1}} : ln;
  endtask

  task automatic wr(input string tag, input int a, input bit g, input logic [LN-1:0] ln);
    step(tag, 1, 1, g, ln, a, $urandom, 0);
  endtask
  task automatic rd(input string tag, input int a, input logic [DW-1:0] d);
    step(tag, 1, 0, 0, '0, a, d, 0);
  endtask
  task automatic idle(input string tag, input logic [DW-1:0] d);
    step(tag, 0, 0, 0, '0, 0, d, 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [DW-1:0] dv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {{(DW-1){1'b0}}, dout_en}, '0);
    rst_n = 1'b1;
    // R5 full-word writes with all_lanes, lane_en zero
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sel = 1; wr_en = 1; all_lanes = 1; lane_en = '0; addr = AWB'(i); pdn = 0;
      dv = {$urandom, 4'(i)};
      if (m_pend_v) begin
        ref_mem[m_pend_addr] = din;
      end
      m_pend_v = 1; m_pend_addr = i; m_pend_mask = '1;
      @(posedge clk);
      #1 din = {$urandom, 4'(i)};
    end
    // data for the last write arrives with this idle step
    idle("R2", din);
    // R2 read back each word
    for (int i = 0; i < 8; i++) rd("R2", i, '0);
    idle("R1", '0);
    idle("R1", '0);
    // R3 R4 back-to-back write then read, partial masks
    for (int i = 0; i < 16; i++) begin
      step("R4", 1, 1, 0, 4'(i), i % 8, '0, 0);
      rd("R3", i % 8, {$urandom, 4'(i)});
    end
    // R3 two writes then reads of both (direct commit path)
    wr("R3", 1, 0, 4'b0101);
    wr("R3", 2, 0, 4'b1010);
    rd("R3", 1, {$urandom, 4'hA});
    rd("R3", 2, '0);
    idle("R3", '0);
    idle("R3", '0);
    // R7 write, then power-down edge carries its data; write under pdn ignored
    wr("R7", 3, 1, '0);
    step("R7", 1, 1, 1, '1, 4, {$urandom, 4'h7}, 1);
    step("R7", 1, 0, 0, '0, 4, '0, 1);
    rd("R7", 3, {$urandom, 4'h3});
    rd("R7", 4, {$urandom, 4'h5});
    idle("R7", '0);
    idle("R7", '0);
    // R8 deselected write attempt ignored
    step("R8", 0, 1, 1, '1, 5, '0, 0);
    step("R8", 0, 1, 1, '1, 5, {$urandom, 4'h9}, 0);
    rd("R8", 5, {$urandom, 4'h1});
    idle("R8", '0);
    idle("R8", '0);
    // R6 asynchronous output enable inside one cycle
    rd("R6", 6, '0);
    idle("R6", '0);
    @(negedge clk);
    look("R6");
    oe = 1'b0;
    #0.5;
    chk("R6", {{(DW-1){1'b0}}, dout_en}, '0);
    chk("R6", dout, '0);
    oe = 1'b1;
    #0.5;
    chk("R6", {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, 1'b1});
    chk("R6", dout, exp_dout);
    exp_vld = m_rd_v;
    m_rd_v = 0;
    sel = 0;
    // R3 R9 random mix with overlapping buffer activity
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      oe = (r != 0);
      step("R3", (r != 1), r[0], (r == 2), 4'($urandom), $urandom % 8, {$urandom, 4'(r)}, (r == 3));
    end
    oe = 1'b1;
    idle("R3", '0);
    idle("R3", '0);
    idle("R3", '0);
    summary();
  end
endmodule